// File: doc/BRIEF.md
# RTC Alarm Match Controller

This block watches a running calendar time and raises an alarm when that time reaches a programmed point. Six alarm bytes hold target values for seconds, minutes, hours, day of month, month and weekday. Each byte carries its own enable bit. Only the enabled bytes take part in the comparison, so a user can program a single field, a chosen subset of fields, or all six. An external timekeeping counter supplies the current time as BCD bytes. It also supplies a one-cycle tick in each cycle where that time has just been updated.

There are two alarm modes. In one-shot mode a match sets a sticky alarm flag, and the active-low interrupt output stays low until software clears the flag. Software clears it either by writing zero to the status bit, or by reading status with auto-clear enabled. In periodic mode every match sets the flag and drives a low pulse of fixed length on the interrupt output. The pulses repeat on every match, whether or not the flag has been cleared. All registers are reached through a small strobe-based write/read port. The block assumes that nothing else shares the interrupt output: any frequency-output function must be turned off while the alarm is in use.

Top module: `rtc_alarm_match`

## Requirements
- R1: Register map. Addresses 0 to 5 are the alarm bytes for seconds, minutes, hours, day of month, month and weekday. In each alarm byte, bit 7 is the enable and bits 6:0 are the BCD compare value. Address 6 is control: bit 0 selects periodic mode and bit 1 enables auto-clear on read. Address 7 is status, with the alarm flag in bit 0. Any other address reads as 0. Read data appears on the cycle after the read strobe.
- R2: After reset, all alarm bytes and the control register are 0, the alarm flag is 0 and the interrupt output is high.
- R3: A match is evaluated only in a cycle where the tick is high. It requires every enabled field, compared on bits 6:0, to equal the current time. It fires only if the previous tick did not also match, so the alarm fires on entry into the matching time and not while that time persists.
- R4: If no alarm byte has bit 7 set, no match ever fires.
- R5: In one-shot mode (control bit 0 = 0), a match sets the flag and drives the interrupt output low from the first clock edge after the tick. The output stays low until the flag is cleared.
- R6: Writing status with bit 0 = 0 clears the flag. Writing status with bit 0 = 1 has no effect.
- R7: When control bit 1 is 1, a status read returns the flag as it was before the read and then clears it. When control bit 1 is 0, a status read leaves the flag unchanged.
- R8: In periodic mode (control bit 0 = 1), every match sets the flag and drives the interrupt output low for exactly PULSE_LEN clock cycles. Later matches pulse again even if the flag was never cleared.
- R9: With only the seconds byte enabled, at value 30, periodic mode gives one pulse per 60 ticks of seconds-rate time.
- R10: A match and a flag clear in the same cycle, whether the clear comes from a status write or from an auto-clearing status read, leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe: the time inputs were just updated |
| tm_sec_i | input | 8 | Current seconds, BCD |
| tm_min_i | input | 8 | Current minutes, BCD |
| tm_hour_i | input | 8 | Current hours, BCD, 24-hour |
| tm_date_i | input | 8 | Current day of month, BCD |
| tm_month_i | input | 8 | Current month, BCD |
| tm_wday_i | input | 8 | Current weekday |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, valid the cycle after the read strobe |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Two events can fall in the same cycle: a fresh match, and a clear of the flag by either route. The bench provokes this by asserting the tick with a time that has just become matching. In that same cycle it issues either an auto-clearing status read or a status write of zero. The result is judged at the following cycle: the flag must read 1 and the interrupt must still be low. A later plain clear then shows that the flag can still be cleared.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants for the RTC alarm match controller.
// Assumes byte-wide registers with the enable bit at the top.
package rtc_alarm_pkg;
    localparam int NUM_FIELDS  = 6;
    localparam int FIELD_SEC   = 0;
    localparam int FIELD_MIN   = 1;
    localparam int FIELD_HOUR  = 2;
    localparam int FIELD_DATE  = 3;
    localparam int FIELD_MONTH = 4;
    localparam int FIELD_WDAY  = 5;
    localparam int ADDR_CTRL   = 6;
    localparam int ADDR_STAT   = 7;

    // Control register: bit 1 auto-clear, bit 0 periodic mode.
    typedef struct packed {
        logic auto_clr;
        logic periodic;
    } ctrl_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
// Register file: alarm bytes, control bits and status access.
// Read data is registered. The clear request is produced combinationally
// for the flag logic, which decides priority against a new match.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_i,
    input  logic                                rd_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic                                flag_i,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0]   alarm_o,
    output ctrl_t                               ctrl_o,
    output logic                                clr_req_o,
    output logic [DATA_W-1:0]                   rdata_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q;
    ctrl_t                             ctrl_q;
    logic [DATA_W-1:0]                 rd_val;
    logic                              sel_ctrl;
    logic                              sel_stat;

    assign sel_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (addr_i == ADDR_W'(ADDR_STAT));

    // One storage byte per alarm field.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        // Purpose: store a written alarm byte.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                alarm_q[i] <= '0;
            end else if (wr_i && addr_i == ADDR_W'(i)) begin
                alarm_q[i] <= wdata_i;
            end
        end
    end

    // Purpose: store the mode bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (wr_i && sel_ctrl) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    // Purpose: clear request from a zero write or an auto-clearing read.
    assign clr_req_o = (wr_i && sel_stat && !wdata_i[0])
                     || (rd_i && sel_stat && ctrl_q.auto_clr);

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rd_val = alarm_q[i];
            end
        end
        if (sel_ctrl) begin
            rd_val = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        end
        if (sel_stat) begin
            rd_val = {{(DATA_W-1){1'b0}}, flag_i};
        end
    end

    // Purpose: register the read data on a read strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= rd_val;
        end
    end

    assign alarm_o = alarm_q;
    assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Field comparator: builds an entry-edge match event from the enabled fields.
// Assumes the time bytes are stable whenever tick_i is high.
module rtc_alarm_cmp #(
    parameter int NUM_FIELDS = 6,
    parameter int DATA_W     = 8
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              tick_i,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_i,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_i,
    output logic                              fire_o,
    output logic                              any_en_o
);
    localparam int VAL_W = DATA_W - 1;

    logic [NUM_FIELDS-1:0] en;
    logic [NUM_FIELDS-1:0] hit;
    logic [NUM_FIELDS-1:0] now_msb;
    logic                  match;
    logic                  prev_q;
    logic                  unused_now_msb;

    // One compare lane per field; a disabled lane always hits.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_lane
        assign en[i]      = alarm_i[i][DATA_W-1];
        assign hit[i]     = !en[i] || (alarm_i[i][VAL_W-1:0] == now_i[i][VAL_W-1:0]);
        assign now_msb[i] = now_i[i][DATA_W-1];
    end

    assign unused_now_msb = ^now_msb;
    assign any_en_o       = |en;
    assign match          = any_en_o && (&hit);

    // Purpose: remember whether the previous tick matched.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else if (tick_i) begin
            prev_q <= match;
        end
    end

    // Purpose: fire only on entry into a matching time.
    assign fire_o = tick_i && match && !prev_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
// Flag and interrupt driver. One-shot mode drives the output level from the
// flag; periodic mode drives a fixed-length pulse. Assumes PULSE_LEN >= 1.
module rtc_alarm_irq #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic periodic_i,
    input  logic clr_req_i,
    output logic flag_o,
    output logic irq_no
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: sticky flag; a new match wins over a clear in the same cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (fire_i) begin
            flag_q <= 1'b1;
        end else if (clr_req_i) begin
            flag_q <= 1'b0;
        end
    end

    // Purpose: count down the periodic pulse length.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (fire_i && periodic_i) begin
            cnt_q <= CNT_W'(PULSE_LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: select the output behaviour by mode.
    assign irq_no = periodic_i ? (cnt_q == '0) : !flag_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/rtc_alarm_match.sv
// Top of the RTC alarm match controller. Packs the time bytes into field
// order and wires the register file, comparator and interrupt driver.
// Assumes the interrupt pin is not shared with a frequency output.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] tm_sec_i,
    input  logic [DATA_W-1:0] tm_min_i,
    input  logic [DATA_W-1:0] tm_hour_i,
    input  logic [DATA_W-1:0] tm_date_i,
    input  logic [DATA_W-1:0] tm_month_i,
    input  logic [DATA_W-1:0] tm_wday_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              alarm_flag_o,
    output logic              irq_no
);
    logic [NUM_FIELDS-1:0][DATA_W-1:0] now;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm;
    ctrl_t                             ctrl;
    logic                              clr_req;
    logic                              fire;
    logic                              any_en;

    // Purpose: arrange the time bytes in register-map order.
    always_comb begin
        now[FIELD_SEC]   = tm_sec_i;
        now[FIELD_MIN]   = tm_min_i;
        now[FIELD_HOUR]  = tm_hour_i;
        now[FIELD_DATE]  = tm_date_i;
        now[FIELD_MONTH] = tm_month_i;
        now[FIELD_WDAY]  = tm_wday_i;
    end

    rtc_alarm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .flag_i    (alarm_flag_o),
        .alarm_o   (alarm),
        .ctrl_o    (ctrl),
        .clr_req_o (clr_req),
        .rdata_o   (bus_rdata_o)
    );

    rtc_alarm_cmp #(
        .NUM_FIELDS (NUM_FIELDS),
        .DATA_W     (DATA_W)
    ) cmp_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .now_i    (now),
        .alarm_i  (alarm),
        .fire_o   (fire),
        .any_en_o (any_en)
    );

    rtc_alarm_irq #(
        .PULSE_LEN (PULSE_LEN)
    ) irq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (fire),
        .periodic_i (ctrl.periodic),
        .clr_req_i  (clr_req),
        .flag_o     (alarm_flag_o),
        .irq_no     (irq_no)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Assertion checker for rtc_alarm_match, attached by bind.
module rtc_alarm_match_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic fire_i,
    input logic any_en_i,
    input logic flag_i,
    input logic irq_ni,
    input logic periodic_i,
    input logic clr_req_i,
    input logic wr_i
);
    // R3: a match event only occurs in a tick cycle.
    assert_fire_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |-> tick_i);

    // R4: with no field enabled, no match event occurs.
    assert_no_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_en_i |-> !fire_i);

    // R10: a match sets the flag even when a clear is requested alongside it.
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> flag_i);

    // R5: in one-shot mode the flag holds until a clear is requested.
    assert_oneshot_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !clr_req_i) |=> flag_i);

    // R6: a clear without a competing match drops the flag.
    assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_req_i && !fire_i) |=> !flag_i);

    // R8: a periodic match pulls the interrupt low on the next cycle.
    assert_pulse_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (periodic_i && fire_i && !wr_i) |=> !irq_ni);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .fire_i     (fire),
    .any_en_i   (any_en),
    .flag_i     (alarm_flag_o),
    .irq_ni     (irq_no),
    .periodic_i (ctrl.periodic),
    .clr_req_i  (clr_req),
    .wr_i       (bus_wr_i)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb_top;
    localparam int PULSE_LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] t_sec = 8'h00, t_min = 8'h00, t_hour = 8'h00;
    logic [7:0] t_date = 8'h01, t_mon = 8'h01, t_wday = 8'h00;
    logic       wr = 1'b0, rd = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       flag;
    logic       irq_n;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rtc_alarm_match #(.PULSE_LEN(PULSE_LEN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .tm_sec_i(t_sec), .tm_min_i(t_min), .tm_hour_i(t_hour),
        .tm_date_i(t_date), .tm_month_i(t_mon), .tm_wday_i(t_wday),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .alarm_flag_o(flag), .irq_no(irq_n)
    );

    function automatic logic [7:0] bcd(int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic set_time(int h, int m, int s);
        t_hour = bcd(h); t_min = bcd(m); t_sec = bcd(s);
    endtask

    // One tick cycle, optionally with a status read or status write beside it.
    task automatic tick_cycle(bit do_rd, bit do_wr, logic [7:0] wd);
        @(negedge clk);
        tick = 1'b1;
        rd = do_rd; wr = do_wr; addr = 4'd7; wdata = wd;
        @(negedge clk);
        tick = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic clear_fields();
        for (int i = 0; i < 6; i++) reg_write(4'(i), 8'h00);
        reg_write(4'd6, 8'h00);
        reg_write(4'd7, 8'h00);
        idle(PULSE_LEN + 2);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        check("R2 irq after reset", irq_n, 1);
        check("R2 flag after reset", flag, 0);
        reg_read(4'd0, d); check("R2 alarm byte reset", d, 8'h00);
        reg_read(4'd6, d); check("R2 control reset", d, 8'h00);
    endtask

    task automatic test_regmap();
        logic [7:0] d;
        reg_write(4'd0, 8'hB0);
        reg_read(4'd0, d); check("R1 alarm byte readback", d, 8'hB0);
        reg_write(4'd6, 8'h03);
        reg_read(4'd6, d); check("R1 control readback", d, 8'h03);
        reg_read(4'd9, d); check("R1 unmapped address", d, 8'h00);
        clear_fields();
    endtask

    task automatic test_no_enable();
        int seen = 0;
        for (int s = 0; s < 5; s++) begin
            set_time(0, 0, s);
            tick_cycle(0, 0, 8'h00);
            if (flag || !irq_n) seen++;
        end
        check("R4 no fields enabled", seen, 0);
    endtask

    task automatic test_oneshot();
        logic [7:0] d;
        reg_write(4'd2, 8'h91);
        reg_write(4'd1, 8'hB0);
        set_time(11, 29, 59); tick_cycle(0, 0, 8'h00);
        check("R3 no match before time", flag, 0);
        set_time(11, 30, 0); tick_cycle(0, 0, 8'h00);
        check("R5 flag on match", flag, 1);
        check("R5 irq low on match", irq_n, 0);
        reg_read(4'd7, d);
        check("R7 status read value", d, 8'h01);
        check("R7 read without auto-clear keeps flag", flag, 1);
        set_time(11, 30, 1); tick_cycle(0, 0, 8'h00);
        check("R5 irq held low", irq_n, 0);
        reg_write(4'd7, 8'h00);
        check("R6 zero write clears flag", flag, 0);
        check("R5 irq released after clear", irq_n, 1);
        set_time(11, 30, 2); tick_cycle(0, 0, 8'h00);
        check("R3 no refire within matching time", flag, 0);
        reg_write(4'd7, 8'h01);
        check("R6 write of one ignored", flag, 0);
        check("R6 irq unaffected by write of one", irq_n, 1);
        clear_fields();
    endtask

    task automatic test_autoclear();
        logic [7:0] d;
        reg_write(4'd6, 8'h02);
        reg_write(4'd5, 8'h83);
        t_wday = 8'h02; tick_cycle(0, 0, 8'h00);
        check("R3 weekday mismatch", flag, 0);
        t_wday = 8'h03; tick_cycle(0, 0, 8'h00);
        check("R3 weekday match", flag, 1);
        reg_read(4'd7, d);
        check("R7 read returns set flag", d, 8'h01);
        check("R7 auto-clear flag", flag, 0);
        check("R7 auto-clear irq", irq_n, 1);
        reg_read(4'd7, d);
        check("R7 second read returns zero", d, 8'h00);
    endtask

    task automatic test_collision();
        t_wday = 8'h04; tick_cycle(0, 0, 8'h00);
        t_wday = 8'h03; tick_cycle(1, 0, 8'h00);
        check("R10 match beats auto-clear read", flag, 1);
        check("R10 irq low after collision read", irq_n, 0);
        t_wday = 8'h04; tick_cycle(0, 0, 8'h00);
        t_wday = 8'h03; tick_cycle(0, 1, 8'h00);
        check("R10 match beats zero write", flag, 1);
        reg_write(4'd7, 8'h00);
        check("R10 later clear works", flag, 0);
        t_wday = 8'h00;
        clear_fields();
    endtask

    task automatic test_periodic();
        int pulses = 0;
        int low_len = 0;
        reg_write(4'd0, 8'hB0);
        reg_write(4'd6, 8'h01);
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 60; s++) begin
                set_time(5, m, s);
                tick_cycle(0, 0, 8'h00);
                if (!irq_n) begin
                    pulses++;
                    if (m == 0) begin
                        low_len = 1;
                        for (int k = 0; k < PULSE_LEN + 2; k++) begin
                            @(negedge clk);
                            if (!irq_n) low_len++;
                        end
                        check("R8 flag set by pulse", flag, 1);
                    end else begin
                        idle(PULSE_LEN + 2);
                    end
                end else begin
                    idle(2);
                end
            end
        end
        check("R8 pulse length", low_len, PULSE_LEN);
        check("R9 one pulse per minute", pulses, 2);
        check("R8 flag still set without clearing", flag, 1);
        clear_fields();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regmap();
        test_no_enable();
        test_oneshot();
        test_autoclear();
        test_collision();
        test_periodic();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule